// File: doc/BRIEF.md
# Black Level Clamp Loop Controller

This block is a digital feedback loop that removes residual offset from an image sensor signal path. Each line contains a short run of shielded dark pixels, marked by a window strobe. While the strobe is high, the block takes every valid converter sample and subtracts from it a programmable black target. It sums these errors over the window. When the window closes, it averages the sum and applies a loop gain. It then moves a correction code, which drives an offset DAC placed ahead of the converter, against the average error.

The target is an 8-bit value with quarter-LSB resolution. Corrections are committed at most once per line. A line-skip count lowers the update rate for slow tracking. A loop enable turns the feedback off. While the loop is off, the target value itself is presented on the DAC output as a fixed offset.

Top module: `blk_clamp_loop`

## Requirements
- R1: After reset, with the loop enabled, the DAC code output is mid-scale (512 for a 10-bit code).
- R2: The error of each sample is computed in quarter-LSB units as sample*4 - target. The 8-bit target covers 0 to 63.75 LSB, so target code k means k/4 LSB.
- R3: A sample is accumulated only when its valid flag is high and the window strobe is high in the same cycle. Samples outside the window have no effect on the correction.
- R4: When the window strobe falls, the error sum is divided by the number of accumulated samples, truncating toward zero, to give the mean. The mean is then shifted arithmetically right by GAIN_SHIFT (default 2), which rounds toward minus infinity. The correction code is decreased by this step.
- R5: The correction code saturates at 0 and at 2^DAC_W-1 and never wraps.
- R6: A window that contains no valid samples leaves the correction code unchanged.
- R7: The first line start after reset is a commit line. The skip counter is loaded from the line-skip input on a commit line start and is decremented on every other line start. A line start that finds the counter at zero is a commit line. Only a window inside a commit line can change the correction, so a skip value N gives one update every N+1 lines. The change appears only after the window closes.
- R8: While the loop enable is low, the DAC code output equals the target code zero-extended, and the correction register is neither updated nor lost. When the loop is enabled again, the held correction is output.
- R9: At most MAX_WIN (default 1024) samples are accumulated per window; further valid samples in the same window are ignored.
- R10: Windows as short as one valid sample produce a correction from that single sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_i | input | 10 | Converter sample |
| smp_vld_i | input | 1 | Sample valid |
| dark_win_i | input | 1 | High during the shielded-pixel window |
| line_start_i | input | 1 | One-cycle pulse at the start of each line |
| target_i | input | 8 | Black target in quarter-LSB units |
| loop_en_i | input | 1 | Loop enable; low turns the target into a static offset |
| line_skip_i | input | 4 | Number of lines skipped between commits |
| dac_code_o | output | 10 | Correction code for the offset DAC |

## Verification
The bench targets several corner cases, each with a visible failure mode:
- Rounding of a negative mean: a divider that floors where it should truncate, or a shift that truncates, ends one code off.
- A push beyond either rail: a design without saturation wraps to the opposite end of the code range.
- Empty windows and over-long windows: a design without a zero-count guard divides by zero, and one without the sample cap folds tail samples into the mean.
- Off-window valid samples of full-scale value: these would drag the code if they leaked into the sum.
- Skip counts and loop disable: mis-phased skip counting commits on the wrong lines, and a disable path that resets or updates the correction returns the wrong code when the loop is re-enabled.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/clamp_err_acc.sv
module clamp_err_acc #(
    parameter int SAMPLE_W = 10,
    parameter int TARGET_W = 8,
    parameter int MAX_WIN  = 1024,
    parameter int ACC_W    = 24,
    parameter int CNT_W    = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SAMPLE_W-1:0]     smp_i,
    input  logic                    smp_vld_i,
    input  logic                    win_i,
    input  logic [TARGET_W-1:0]     target_i,
    output logic                    win_end_o,
    output logic signed [ACC_W-1:0] sum_o,
    output logic [CNT_W-1:0]        cnt_o
);
    localparam int ERR_W = SAMPLE_W + 3;

    typedef struct packed {
        logic                    win;
        logic signed [ACC_W-1:0] acc;
        logic [CNT_W-1:0]        cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic signed [ERR_W-1:0] err;

    always_comb begin
        err  = $signed({1'b0, smp_i, 2'b00}) - $signed({{(ERR_W-TARGET_W){1'b0}}, target_i});
        st_d = st_q;
        st_d.win = win_i;
        if (st_q.win && !win_i) begin
            st_d.acc = '0;
            st_d.cnt = '0;
        end else if (win_i && smp_vld_i && (st_q.cnt < CNT_W'(MAX_WIN))) begin
            st_d.acc = st_q.acc + {{(ACC_W-ERR_W){err[ERR_W-1]}}, err};
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_end_o = st_q.win && !win_i;
    assign sum_o     = st_q.acc;
    assign cnt_o     = st_q.cnt;
endmodule

// File: rtl/clamp_div.sv
module clamp_div
    import clamp_pkg::*;
#(
    parameter int NUM_W = 24,
    parameter int DEN_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int IT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        div_state_e       st;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic [IT_W-1:0]  it;
        logic             done;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           fits;

    always_comb begin
        trial = {st_q.rem, st_q.quo[NUM_W-1]};
        diff  = trial - {1'b0, st_q.den};
        fits  = trial >= {1'b0, st_q.den};
        st_d  = st_q;
        st_d.done = 1'b0;
        case (st_q.st)
            DIV_IDLE: begin
                if (start_i) begin
                    st_d.st  = DIV_RUN;
                    st_d.rem = '0;
                    st_d.quo = num_i;
                    st_d.den = den_i;
                    st_d.it  = IT_W'(NUM_W);
                end
            end
            default: begin
                st_d.rem = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
                st_d.quo = {st_q.quo[NUM_W-2:0], fits};
                st_d.it  = st_q.it - 1'b1;
                if (st_q.it == IT_W'(1)) begin
                    st_d.st   = DIV_IDLE;
                    st_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{st: DIV_IDLE, default: '0};
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.st == DIV_RUN);
    assign done_o = st_q.done;
    assign quo_o  = st_q.quo;
endmodule

// File: rtl/clamp_pace.sv
module clamp_pace #(
    parameter int SKIP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start_i,
    input  logic [SKIP_W-1:0] skip_i,
    output logic              arm_o
);
    typedef struct packed {
        logic [SKIP_W-1:0] cnt;
    } pace_st_t;

    pace_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        arm_o = line_start_i && (st_q.cnt == '0);
        if (line_start_i) begin
            st_d.cnt = (st_q.cnt == '0) ? skip_i : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/blk_clamp_loop.sv
module blk_clamp_loop #(
    parameter int SAMPLE_W   = 10,
    parameter int TARGET_W   = 8,
    parameter int DAC_W      = 10,
    parameter int SKIP_W     = 4,
    parameter int MAX_WIN    = 1024,
    parameter int GAIN_SHIFT = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] smp_i,
    input  logic                smp_vld_i,
    input  logic                dark_win_i,
    input  logic                line_start_i,
    input  logic [TARGET_W-1:0] target_i,
    input  logic                loop_en_i,
    input  logic [SKIP_W-1:0]   line_skip_i,
    output logic [DAC_W-1:0]    dac_code_o
);
    localparam int CNT_W   = $clog2(MAX_WIN + 1);
    localparam int ACC_W   = SAMPLE_W + 4 + $clog2(MAX_WIN);
    localparam int WIDE_W  = ACC_W + 1;
    localparam logic [DAC_W-1:0] CODE_MID = DAC_W'(1) << (DAC_W - 1);
    localparam logic [DAC_W-1:0] CODE_MAX = '1;

    typedef struct packed {
        logic [DAC_W-1:0] corr;
        logic             arm;
        logic             neg;
    } top_st_t;

    top_st_t st_d, st_q;

    logic                    win_end;
    logic signed [ACC_W-1:0] win_sum;
    logic [CNT_W-1:0]        win_cnt;
    logic [ACC_W-1:0]        sum_mag;
    logic                    arm_pulse;
    logic                    div_start;
    logic                    div_busy;
    logic                    div_done;
    logic [ACC_W-1:0]        div_quo;
    logic [DAC_W-1:0]        corr_q;
    logic signed [WIDE_W-1:0] mean_s;
    logic signed [WIDE_W-1:0] step_s;
    logic signed [WIDE_W-1:0] next_s;

    clamp_err_acc #(
        .SAMPLE_W (SAMPLE_W),
        .TARGET_W (TARGET_W),
        .MAX_WIN  (MAX_WIN),
        .ACC_W    (ACC_W),
        .CNT_W    (CNT_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (smp_i),
        .smp_vld_i (smp_vld_i),
        .win_i     (dark_win_i),
        .target_i  (target_i),
        .win_end_o (win_end),
        .sum_o     (win_sum),
        .cnt_o     (win_cnt)
    );

    clamp_pace #(.SKIP_W(SKIP_W)) u_pace (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_start_i (line_start_i),
        .skip_i       (line_skip_i),
        .arm_o        (arm_pulse)
    );

    assign sum_mag   = win_sum[ACC_W-1] ? ACC_W'(-win_sum) : ACC_W'(win_sum);
    assign div_start = win_end && st_q.arm && loop_en_i && (win_cnt != '0) && !div_busy;

    clamp_div #(.NUM_W(ACC_W), .DEN_W(CNT_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (div_start),
        .num_i   (sum_mag),
        .den_i   (win_cnt),
        .busy_o  (div_busy),
        .done_o  (div_done),
        .quo_o   (div_quo)
    );

    always_comb begin
        st_d   = st_q;
        mean_s = st_q.neg ? -$signed({1'b0, div_quo}) : $signed({1'b0, div_quo});
        step_s = mean_s >>> GAIN_SHIFT;
        next_s = $signed({{(WIDE_W-DAC_W){1'b0}}, st_q.corr}) - step_s;
        if (arm_pulse) begin
            st_d.arm = 1'b1;
        end else if (win_end) begin
            st_d.arm = 1'b0;
        end
        if (div_start) begin
            st_d.neg = win_sum[ACC_W-1];
        end
        if (div_done && loop_en_i) begin
            if (next_s < 0) begin
                st_d.corr = '0;
            end else if (next_s > $signed({{(WIDE_W-DAC_W){1'b0}}, CODE_MAX})) begin
                st_d.corr = CODE_MAX;
            end else begin
                st_d.corr = next_s[DAC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{corr: CODE_MID, arm: 1'b0, neg: 1'b0};
        else        st_q <= st_d;
    end

    assign corr_q     = st_q.corr;
    assign dac_code_o = loop_en_i ? st_q.corr : DAC_W'(target_i);
endmodule

// File: rtl/clamp_loop_chk.sv
module clamp_loop_chk #(
    parameter int DAC_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             loop_en_i,
    input logic             dark_win_i,
    input logic             div_start,
    input logic             div_done,
    input logic [DAC_W-1:0] corr_q
);
    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en_i |=> $stable(corr_q));

    // R7
    commit_after_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_done |=> $stable(corr_q));

    // R3
    start_at_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |-> (!dark_win_i && $past(dark_win_i)));

    // R8
    no_start_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en_i |-> !div_start);
endmodule

bind blk_clamp_loop clamp_loop_chk #(.DAC_W(DAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loop_en_i  (loop_en_i),
    .dark_win_i (dark_win_i),
    .div_start  (div_start),
    .div_done   (div_done),
    .corr_q     (corr_q)
);

// File: tb/blk_clamp_loop_tb_top.sv
`timescale 1ns/1ps
module blk_clamp_loop_tb_top;
    localparam int GAIN = 2;
    localparam int CMAX = 1023;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] smp = '0;
    logic       vld = 1'b0;
    logic       win = 1'b0;
    logic       line_start = 1'b0;
    logic [7:0] target = '0;
    logic       loop_en = 1'b1;
    logic [3:0] line_skip = '0;
    logic [9:0] dac_code;

    int checks = 0;
    int errors = 0;
    int m_corr = 512;
    int m_skip = 0;
    int    exp_q[$];
    string tag_q[$];
    event  chk_ev;

    always #5 clk = ~clk;

    blk_clamp_loop dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .smp_i        (smp),
        .smp_vld_i    (vld),
        .dark_win_i   (win),
        .line_start_i (line_start),
        .target_i     (target),
        .loop_en_i    (loop_en),
        .line_skip_i  (line_skip),
        .dac_code_o   (dac_code)
    );

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: pops expected codes and compares at the sample point
    initial begin
        forever begin
            @(chk_ev);
            if (exp_q.size() != 0) begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(int'(dac_code), e, t);
            end
        end
    end

    // driver: one line with a window of n cycles; also predicts the result
    task automatic run_line(input int n, input int s0, input int s1, input int tgt,
                            input int skip, input bit en, input int vld_every,
                            input string tag);
        int sum = 0;
        int cnt = 0;
        bit commit;
        @(posedge clk); #1;
        target = 8'(tgt); line_skip = 4'(skip); loop_en = en;
        line_start = 1'b1; smp = 10'd1023; vld = 1'b1; win = 1'b0;
        @(posedge clk); #1;
        line_start = 1'b0;
        @(posedge clk); #1;
        for (int i = 0; i < n; i++) begin
            int s;
            bit v;
            s = (i >= 1024) ? 1023 : ((i % 2) != 0 ? s1 : s0);
            v = (vld_every != 0) && ((i % vld_every) == 0);
            win = 1'b1; smp = 10'(s); vld = v;
            if (v && cnt < 1024) begin
                sum += s * 4 - tgt;
                cnt++;
            end
            @(posedge clk); #1;
        end
        win = 1'b0; smp = 10'd1023; vld = 1'b1;
        repeat (45) @(posedge clk);
        commit = (m_skip == 0);
        m_skip = commit ? skip : m_skip - 1;
        if (commit && en && cnt > 0) begin
            int mean;
            mean = sum / cnt;
            m_corr = m_corr - (mean >>> GAIN);
            if (m_corr < 0) m_corr = 0;
            if (m_corr > CMAX) m_corr = CMAX;
        end
        exp_q.push_back(en ? m_corr : tgt);
        tag_q.push_back(tag);
        @(negedge clk);
        ->chk_ev;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(int'(dac_code), 512, "R1 reset mid-scale");

        run_line(20, 10, 10, 40, 0, 1'b1, 1, "R2 balanced window");
        run_line(20, 200, 200, 40, 0, 1'b1, 1, "R4 positive error step");
        run_line(4, 10, 10, 41, 0, 1'b1, 1, "R2 quarter-LSB target");
        run_line(2, 10, 9, 42, 0, 1'b1, 1, "R4 negative mean rounding");
        run_line(3, 11, 10, 41, 0, 1'b1, 1, "R4 small mean truncates");
        run_line(20, 10, 1023, 40, 0, 1'b1, 2, "R3 invalid samples ignored");
        run_line(20, 1023, 1023, 40, 0, 1'b1, 0, "R6 empty window");
        run_line(1, 100, 100, 0, 0, 1'b1, 1, "R10 single sample window");
        run_line(20, 1023, 1023, 0, 0, 1'b1, 1, "R5 low rail");
        for (int k = 0; k < 17; k++) begin
            run_line(20, 0, 0, 255, 0, 1'b1, 1, "R5 climb to high rail");
        end
        run_line(20, 1023, 1023, 0, 2, 1'b1, 1, "R7 commit line with skip");
        run_line(20, 0, 0, 255, 2, 1'b1, 1, "R7 skipped line one");
        run_line(20, 0, 0, 255, 2, 1'b1, 1, "R7 skipped line two");
        run_line(20, 0, 0, 255, 2, 1'b1, 1, "R7 next commit line");
        run_line(20, 0, 0, 255, 0, 1'b1, 1, "R7 skip drain one");
        run_line(20, 0, 0, 255, 0, 1'b1, 1, "R7 skip drain two");
        run_line(20, 0, 0, 255, 0, 1'b1, 1, "R7 commit after drain");
        run_line(20, 1023, 1023, 77, 0, 1'b0, 1, "R8 static offset");
        run_line(20, 0, 0, 200, 0, 1'b0, 1, "R8 static offset second");
        run_line(20, 10, 10, 40, 0, 1'b1, 1, "R8 correction kept");
        run_line(1030, 10, 10, 40, 0, 1'b1, 1, "R9 window cap");
        run_line(20, 100, 100, 40, 0, 1'b1, 1, "R4 after long window");

        repeat (5) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule